// File: doc/BRIEF.md
# Watchdog and Reset-Cause Controller

This block produces the single system reset of a chip region and records why that reset happened. Five events can trigger the reset: power-on, the external reset pin, a brown-out flag, a software request, and expiry of a watchdog timer. The power-on, pin, brown-out and watchdog inputs pull the reset down immediately, with no clock edge needed. Release is always synchronised to the system clock, and the reset is stretched so that downstream logic sees it for several cycles.

The watchdog counter runs on a slow, always-on clock. It keeps counting while the system clock is gated off, and its expiry pulls the reset down even when no system clock is running. Firmware arms the watchdog and sets its timeout through a small write port. It services the watchdog with a one-cycle kick strobe. A five-bit cause register accumulates one bit per source. Only power-on and explicit write-one-to-clear accesses clear it, so the register outlives every other reset it logs.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: With `rst_ni` low, `xres_ni` low, `bod_i` high, or the watchdog expired, `sys_rst_no` is low without waiting for any `clk_i` edge.
- R2: After the last asynchronous source is removed, `sys_rst_no` rises at the 7th rising `clk_i` edge (two synchroniser stages, then four hold cycles, then the output flop).
- R3: `sw_rst_i` high at a rising edge drives `sys_rst_no` low after that edge. The reset rises again at the 5th rising edge after it.
- R4: The cause bits are: bit 0 power-on, bit 1 external pin, bit 2 brown-out, bit 3 software request, bit 4 watchdog. Each source sets its own bit.
- R5: A power-on reset leaves the cause register at 5'b00001. No other reset clears any cause bit.
- R6: A write to address 2 clears each cause bit whose write-data bit is 1 and leaves the others unchanged. A source setting a bit in the same cycle as its clear leaves the bit set.
- R7: Sources that assert together set all of their cause bits together.
- R8: Bit 0 of address 0 enables the watchdog. Address 1 holds the timeout T in slow-clock cycles. Without a kick, the watchdog reset asserts T+2 to T+4 slow edges after the enable write or the last kick.
- R9: Kicks spaced at most T-4 slow cycles apart keep the watchdog from resetting.
- R10: After any reset the watchdog is disabled and never fires, however long it waits.
- R11: The watchdog counts on `slow_clk_i` and asserts `sys_rst_no` low while `clk_i` is stopped.
- R12: Every system reset clears the enable bit and restores the default timeout. After a watchdog reset, no further watchdog reset occurs until firmware enables it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, may be stopped in deep sleep |
| slow_clk_i | input | 1 | Always-on low-power clock for the watchdog |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| xres_ni | input | 1 | External reset pin, active low, asynchronous |
| bod_i | input | 1 | Brown-out flag, active high, asynchronous |
| sw_rst_i | input | 1 | Software reset request, sampled on `clk_i` |
| kick_i | input | 1 | Watchdog service strobe, one `clk_i` cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address (0 control, 1 timeout, 2 cause clear) |
| wdata_i | input | DATA_W | Register write data |
| sys_rst_no | output | 1 | System reset, active low |
| cause_o | output | 5 | Sticky reset-cause register |

## Verification
The bench measures the exact release edge after each asynchronous source and after a software request. A miscounted synchroniser or hold stage shows up as an early or late rising edge. It raises two sources at once and issues a clear in the same cycle as a software request. This catches a design that logs only one cause or lets the clear win. It then lets the watchdog expire both with the system clock running and with it stopped. A watchdog tied to the fast clock would never fire while that clock is stopped, and one whose enable survives its own reset would fire again and again.

// File: rtl/wdt_rst_pkg.sv
package wdt_rst_pkg;
  localparam int unsigned CAUSE_W  = 5;
  localparam int unsigned ASRC_N   = 3;
  // cause bit positions
  localparam int unsigned CS_POR   = 0;
  localparam int unsigned CS_PIN   = 1;
  localparam int unsigned CS_BROWN = 2;
  localparam int unsigned CS_SOFT  = 3;
  localparam int unsigned CS_WDOG  = 4;
  // register addresses
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_TMO   = 1;
  localparam int unsigned REG_CAUSE = 2;
endpackage

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 4
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic soft_i,
  output logic rst_no
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          hold_q;
  logic                   released;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign released = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)                      hold_q <= CW'(HOLD_CYC);
    else if (soft_i)                   hold_q <= CW'(HOLD_CYC);
    else if (released && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) rst_no <= 1'b0;
    else          rst_no <= released && (hold_q == '0) && !soft_i;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             slow_clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             kick_tgl_i,
  output logic             bite_o
);
  logic [1:0]       en_s;
  logic [2:0]       kick_s;
  logic [TMO_W-1:0] cnt_q;
  logic             kick_evt;

  assign kick_evt = kick_s[2] ^ kick_s[1];

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s   <= '0;
      kick_s <= '0;
      cnt_q  <= '0;
      bite_o <= 1'b0;
    end else begin
      en_s   <= {en_s[0], en_i};
      kick_s <= {kick_s[1:0], kick_tgl_i};
      if (!en_s[1]) begin
        cnt_q  <= '0;
        bite_o <= 1'b0;
      end else if (kick_evt) begin
        cnt_q <= '0;
      end else if (cnt_q == tmo_i) begin
        bite_o <= 1'b1; // held until enable drops
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cause_log.sv
module cause_log
  import wdt_rst_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ASRC_N-1:0]  async_src_i,
  input  logic               soft_i,
  input  logic [CAUSE_W-1:0] clr_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic por_q, soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             por_q <= 1'b1;
    else if (clr_i[CS_POR])  por_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             soft_q <= 1'b0;
    else if (soft_i)         soft_q <= 1'b1;
    else if (clr_i[CS_SOFT]) soft_q <= 1'b0;
  end

  assign cause_o[CS_POR]  = por_q;
  assign cause_o[CS_SOFT] = soft_q;

  for (genvar g = 0; g < ASRC_N; g++) begin : g_async
    localparam int unsigned IDX = (g == 0) ? CS_PIN : ((g == 1) ? CS_BROWN : CS_WDOG);
    logic src_w, q;
    assign src_w = async_src_i[g];
    // async set: pulses shorter than a clock period are still logged
    always_ff @(posedge clk_i or negedge rst_ni or posedge src_w) begin
      if (!rst_ni)         q <= 1'b0;
      else if (src_w)      q <= 1'b1;
      else if (clr_i[IDX]) q <= 1'b0;
    end
    assign cause_o[IDX] = q;
  end
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
  import wdt_rst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned TMO_INIT    = 255,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 4
) (
  input  logic               clk_i,
  input  logic               slow_clk_i,
  input  logic               rst_ni,
  input  logic               xres_ni,
  input  logic               bod_i,
  input  logic               sw_rst_i,
  input  logic               kick_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               sys_rst_no,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               bite;
  logic               arst_n;
  logic               en_q;
  logic [TMO_W-1:0]   tmo_q;
  logic               kick_tgl_q;
  logic [CAUSE_W-1:0] clr;

  assign arst_n = rst_ni & xres_ni & ~bod_i & ~bite;

  rst_seq #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i  (clk_i),
    .arst_ni(arst_n),
    .soft_i (sw_rst_i),
    .rst_no (sys_rst_no)
  );

  // configuration is lost on every system reset
  always_ff @(posedge clk_i or negedge sys_rst_no) begin
    if (!sys_rst_no) begin
      en_q  <= 1'b0;
      tmo_q <= TMO_W'(TMO_INIT);
    end else if (we_i) begin
      if (addr_i == ADDR_W'(REG_CTRL)) en_q  <= wdata_i[0];
      if (addr_i == ADDR_W'(REG_TMO))  tmo_q <= wdata_i[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   kick_tgl_q <= 1'b0;
    else if (kick_i && sys_rst_no) kick_tgl_q <= ~kick_tgl_q;
  end

  wdt_core #(.TMO_W(TMO_W)) u_wdt (
    .slow_clk_i(slow_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .tmo_i     (tmo_q),
    .kick_tgl_i(kick_tgl_q),
    .bite_o    (bite)
  );

  assign clr = (we_i && addr_i == ADDR_W'(REG_CAUSE)) ? wdata_i[CAUSE_W-1:0] : '0;

  cause_log u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_src_i({bite, bod_i, ~xres_ni}),
    .soft_i     (sw_rst_i),
    .clr_i      (clr),
    .cause_o    (cause_o)
  );
endmodule

// File: rtl/wdt_rst_ctrl_chk.sv
module wdt_rst_ctrl_chk
  import wdt_rst_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               xres_ni,
  input logic               bod_i,
  input logic               sw_rst_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [CAUSE_W-1:0] w1c_i,
  input logic               sys_rst_no,
  input logic [CAUSE_W-1:0] cause_o
);
  logic cause_wr;
  assign cause_wr = we_i && (addr_i == ADDR_W'(REG_CAUSE));

  AST_ASYNC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xres_ni || bod_i) |-> !sys_rst_no); // R1

  AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (!$past(sys_rst_no, 1) && !$past(sys_rst_no, 4))); // R2

  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && sw_rst_i) |=> !sys_rst_no); // R3

  AST_SOFT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> cause_o[CS_SOFT]); // R4

  AST_BROWN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bod_i |=> cause_o[CS_BROWN]); // R7

  AST_CLEAR_ONLY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cause_o) & ~cause_o) != '0) |->
      ($past(cause_wr) && ((($past(cause_o) & ~cause_o) & ~$past(w1c_i)) == '0))); // R5
endmodule

bind wdt_rst_ctrl wdt_rst_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .xres_ni   (xres_ni),
  .bod_i     (bod_i),
  .sw_rst_i  (sw_rst_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .w1c_i     (wdata_i[wdt_rst_pkg::CAUSE_W-1:0]),
  .sys_rst_no(sys_rst_no),
  .cause_o   (cause_o)
);

// File: tb/wdt_rst_ctrl_tb_top.sv
module wdt_rst_ctrl_tb_top;
  localparam int TMO = 10;

  logic clk = 1'b0, slow_clk = 1'b0, clk_run = 1'b1;
  logic rst_n = 1'b1, xres_n = 1'b1, bod = 1'b0, sw = 1'b0, kick = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        sys_rst_n;
  logic [4:0]  cause;

  int checks = 0, fails = 0, slow_cnt = 0;
  int m_s = 0, m_c = 4;
  bit m_o = 1'b0, cmp_en = 1'b1;
  logic [4:0] m_cause = 5'h01;

  always #10 clk = clk_run ? ~clk : 1'b0;
  always #80 slow_clk = ~slow_clk;
  always @(posedge slow_clk) slow_cnt++;

  wdt_rst_ctrl dut_i (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n), .xres_ni(xres_n), .bod_i(bod),
    .sw_rst_i(sw), .kick_i(kick), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .sys_rst_no(sys_rst_n), .cause_o(cause)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: cycles since release, hold budget, sticky causes
  always @(posedge clk) begin
    bit nxt;
    if (!rst_n || !xres_n || bod) begin
      m_s = 0; m_c = 4; m_o = 1'b0;
    end else begin
      nxt = (m_s >= 2) && (m_c == 0) && !sw;
      if (sw) m_c = 4;
      else if (m_s >= 2 && m_c > 0) m_c--;
      if (m_s < 2) m_s++;
      m_o = nxt;
    end
    if (!rst_n) m_cause = 5'h01;
    else begin
      if (we && addr == 2'd2) m_cause &= ~wdata[4:0];
      m_cause |= {1'b0, sw, bod, !xres_n, 1'b0};
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      check(sys_rst_n === m_o, "R2 R3 model reset", sys_rst_n, m_o);
      check(cause === m_cause, "R4 R5 R6 model cause", cause, m_cause);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic count_rise(output int n);
    n = 0;
    for (int i = 1; i <= 12 && n == 0; i++) begin
      @(posedge clk); #2;
      if (sys_rst_n) n = i;
    end
  endtask

  task automatic resync();
    m_s = 2; m_c = 0; m_o = 1'b1; m_cause |= 5'h10; cmp_en = 1'b1;
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 400 && !sys_rst_n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, t0;
    #1 rst_n = 1'b0;
    #2 check(sys_rst_n === 1'b0, "R1 por low without clock", sys_rst_n, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    count_rise(n);
    check(n == 7, "R2 release after por", n, 7);
    check(cause === 5'h01, "R5 por cause", cause, 5'h01);

    @(negedge clk); xres_n = 1'b0; #1;
    check(sys_rst_n === 1'b0, "R1 pin async", sys_rst_n, 0);
    repeat (3) @(negedge clk);
    xres_n = 1'b1;
    count_rise(n);
    check(n == 7, "R2 release after pin", n, 7);
    check(cause === 5'h03, "R4 R5 pin bit, por kept", cause, 5'h03);

    wr(2'd2, 16'h001F);
    @(negedge clk);
    check(cause === 5'h00, "R6 clear all", cause, 0);

    @(negedge clk); sw = 1'b1;
    @(posedge clk); #2;
    check(sys_rst_n === 1'b0, "R3 soft assert", sys_rst_n, 0);
    @(negedge clk); sw = 1'b0;
    count_rise(n);
    check(n == 5, "R3 soft release", n, 5);
    check(cause === 5'h08, "R4 soft bit", cause, 5'h08);

    @(negedge clk); bod = 1'b1; #1;
    check(sys_rst_n === 1'b0, "R1 brown async", sys_rst_n, 0);
    repeat (2) @(negedge clk);
    bod = 1'b0;
    count_rise(n);
    check(n == 7, "R2 release after brown", n, 7);
    check(cause === 5'h0C, "R4 R5 brown bit, soft kept", cause, 5'h0C);

    wr(2'd2, 16'h001F);
    @(negedge clk); xres_n = 1'b0; bod = 1'b1;
    repeat (2) @(negedge clk);
    xres_n = 1'b1; bod = 1'b0;
    repeat (10) @(negedge clk);
    check(cause === 5'h06, "R7 simultaneous sources", cause, 5'h06);

    wr(2'd2, 16'h0002);
    @(negedge clk);
    check(cause === 5'h04, "R6 partial clear", cause, 5'h04);
    @(negedge clk); sw = 1'b1; we = 1'b1; addr = 2'd2; wdata = 16'h0008;
    @(negedge clk); sw = 1'b0; we = 1'b0;
    check(cause[3] === 1'b1, "R6 set beats clear", cause[3], 1);
    repeat (10) @(negedge clk);

    t0 = slow_cnt;
    while (slow_cnt - t0 < 40) @(negedge clk);
    check(sys_rst_n === 1'b1, "R10 disabled watchdog silent", sys_rst_n, 1);

    wr(2'd1, 16'(TMO));
    wr(2'd0, 16'h0001);
    t0 = slow_cnt; cmp_en = 1'b0;
    for (int i = 0; i < 4000 && sys_rst_n; i++) @(negedge clk);
    n = slow_cnt - t0;
    check(sys_rst_n === 1'b0, "R8 watchdog fires", sys_rst_n, 0);
    check(n >= TMO + 2 && n <= TMO + 4, "R8 timeout window", n, TMO + 3);
    wait_rise();
    check(sys_rst_n === 1'b1 && cause[4] === 1'b1, "R4 R8 watchdog cause", cause, 5'h10);
    resync();

    t0 = slow_cnt;
    while (slow_cnt - t0 < 30) @(negedge clk);
    check(sys_rst_n === 1'b1, "R12 no repeat after watchdog reset", sys_rst_n, 1);

    wr(2'd1, 16'(TMO));
    wr(2'd0, 16'h0001);
    for (int k = 0; k < 12; k++) begin
      t0 = slow_cnt;
      while (slow_cnt - t0 < 5) @(negedge clk);
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
    end
    check(sys_rst_n === 1'b1, "R9 kicks hold off watchdog", sys_rst_n, 1);

    t0 = slow_cnt; cmp_en = 1'b0;
    @(negedge clk); clk_run = 1'b0;
    for (int i = 0; i < 60 && sys_rst_n; i++) @(posedge slow_clk);
    #1;
    n = slow_cnt - t0;
    check(sys_rst_n === 1'b0 && clk === 1'b0, "R11 fires with clock stopped", sys_rst_n, 0);
    check(n >= TMO + 1 && n <= TMO + 5, "R11 slow-clock timing", n, TMO + 3);
    repeat (4) @(posedge slow_clk);
    clk_run = 1'b1;
    wait_rise();
    check(sys_rst_n === 1'b1 && cause[4] === 1'b1, "R11 release and cause", cause, 5'h10);
    resync();
    wr(2'd2, 16'h0010);
    @(negedge clk);
    check(cause[4] === 1'b0, "R6 clear watchdog bit", cause[4], 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule